// File: doc/BRIEF.md
# I2C Interrupt and Abort Status Unit

This unit sits beside an I2C master sequencer and turns the sequencer's single-cycle event pulses into sticky status bits. It also derives two level-type conditions from the FIFO fill levels and programmable thresholds, applies a mask, and drives one interrupt line. Software clears sticky events by reading dedicated clear registers rather than by writing ones. A catch-all clear register wipes every sticky event at once.

When a transfer is abandoned, the sequencer pulses an abort strobe together with a cause vector. The unit accumulates the causes in an abort-cause register and raises a hold output that keeps the transmit FIFO in reset until the abort is cleared. Threshold writes saturate to the deepest legal value, so writing all ones and reading back reveals the FIFO depth.

All register access is through a simple read/write strobe port with combinational read data. A read strobe on a clear register returns the state before the clear and clears in the same clock edge.

Top module: `i2c_evt_status`

## Requirements
- R1: Raw status bits: bit0 RX underflow, bit1 RX overflow, bit2 TX overflow, bit3 TX abort, bit4 TX empty, bit5 RX full, bit6 START seen, bit7 STOP seen. A pulse on a sticky event input (bits 0-3, 6, 7) sets its bit on the next clock edge and the bit then holds until it is cleared. The raw register reads at address 0.
- R2: Reading a per-event clear register clears only its own bit. The addresses are 7 for RX underflow, 8 for RX overflow, 9 for TX overflow, 10 for TX abort, 11 for START and 12 for STOP.
- R3: Reading the clear-all register at address 6 clears all six sticky bits, including START and STOP. It does not affect the level bits 4 and 5.
- R4: `tx_fifo_hold` is high whenever the TX-abort bit is set. A read of address 10 or 6 releases it on the next edge.
- R5: Thresholds are written and read at address 3 (TX) and address 4 (RX). A written value above FIFO_DEPTH-1 is stored as FIFO_DEPTH-1, so writing all ones reads back as depth minus one.
- R6: Bit 4 is high when `tx_level` <= TX threshold. Bit 5 is high when `rx_level` > RX threshold. Both bits follow the levels combinationally and are not cleared by any clear read.
- R7: The abort-cause register is read at address 5. It ORs in `abort_why` on each abort pulse, with bits: 0 user abort, 1 arbitration lost, 2 no ACK on 7-bit address, 3 no ACK on first 10-bit address byte, 4 no ACK on second 10-bit address byte, 5 no ACK on data, 6 general call not acknowledged, 7 general call with read, 8 restart while restarts disabled, 9 START byte acknowledged. Reads of address 10 or 6 clear it.
- R8: If an event pulse (or an abort cause) arrives in the same cycle as a read that clears it, the bit or cause is set after that edge.
- R9: The mask register is read and written at address 1, bits 7:0. `irq` is the OR of raw AND mask. Address 2 returns raw AND mask.
- R10: After reset the sticky bits, mask, thresholds and abort causes are zero, and `irq` and `tx_fifo_hold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data (pre-clear value) |
| rx_under_p | input | 1 | RX underflow event pulse |
| rx_over_p | input | 1 | RX overflow event pulse |
| tx_over_p | input | 1 | TX overflow event pulse |
| abort_p | input | 1 | Transfer abort pulse |
| abort_why | input | 10 | Abort cause bits, valid with abort_p |
| start_p | input | 1 | START detected pulse |
| stop_p | input | 1 | STOP detected pulse |
| tx_level | input | clog2(FIFO_DEPTH+1) | Transmit FIFO fill level |
| rx_level | input | clog2(FIFO_DEPTH+1) | Receive FIFO fill level |
| irq | output | 1 | Interrupt request |
| tx_fifo_hold | output | 1 | Holds the transmit FIFO in reset while an abort is pending |

## Verification
Two functions can fall in the same cycle: an event pulse setting a sticky bit, and a read that clears that same bit. The bench provokes this for every pairing of each sticky event with each clear register, including clear-all and an abort cause landing on the abort-clear read. It then judges by reading the raw and abort-cause registers afterwards: the event must survive, and any other bit selected by the clear must be gone.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;
  localparam int ADDR_W = 4;
  localparam int ABRT_W = 10;
  localparam int NEV    = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_RAW     = 4'd0,
    A_MASK    = 4'd1,
    A_STAT    = 4'd2,
    A_TXTHR   = 4'd3,
    A_RXTHR   = 4'd4,
    A_ASRC    = 4'd5,
    A_CLRALL  = 4'd6,
    A_CLR_RXU = 4'd7,
    A_CLR_RXO = 4'd8,
    A_CLR_TXO = 4'd9,
    A_CLR_ABT = 4'd10,
    A_CLR_STA = 4'd11,
    A_CLR_STO = 4'd12
  } reg_addr_e;

  // raw status bit positions
  localparam int EV_RXU = 0;
  localparam int EV_RXO = 1;
  localparam int EV_TXO = 2;
  localparam int EV_ABT = 3;
  localparam int EV_TXE = 4;
  localparam int EV_RXF = 5;
  localparam int EV_STA = 6;
  localparam int EV_STO = 7;

  // bits held by a sticky flop (the rest follow FIFO levels)
  localparam logic [NEV-1:0] CLEARABLE = 8'hCF;

  // dedicated clear register of a sticky bit
  function automatic logic [ADDR_W-1:0] clr_addr_of(int unsigned b);
    case (b)
      EV_RXU:  return A_CLR_RXU;
      EV_RXO:  return A_CLR_RXO;
      EV_TXO:  return A_CLR_TXO;
      EV_ABT:  return A_CLR_ABT;
      EV_STA:  return A_CLR_STA;
      EV_STO:  return A_CLR_STO;
      default: return A_CLRALL;
    endcase
  endfunction
endpackage

// File: rtl/i2cev_sticky.sv
module i2cev_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/i2cev_thr_reg.sv
module i2cev_thr_reg #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [DATA_W-1:0]          wdata,
  output logic [$clog2(DEPTH)-1:0]   q
);
  localparam int THR_W = $clog2(DEPTH);
  localparam int TOP   = DEPTH - 1;

  logic             over;
  logic [THR_W-1:0] d;

  assign over = wdata > DATA_W'(TOP);
  assign d    = over ? THR_W'(TOP) : wdata[THR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/i2cev_abort_src.sv
module i2cev_abort_src
  import i2cev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ABRT_W-1:0] why,
  input  logic              clr,
  output logic [ABRT_W-1:0] q
);
  logic [ABRT_W-1:0] keep;
  logic [ABRT_W-1:0] add;

  assign keep = clr ? '0 : q;
  assign add  = capture ? why : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= keep | add;
  end
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2cev_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_rd,
  input  logic                              reg_wr,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [DATA_W-1:0]                 reg_wdata,
  output logic [DATA_W-1:0]                 reg_rdata,
  input  logic                              rx_under_p,
  input  logic                              rx_over_p,
  input  logic                              tx_over_p,
  input  logic                              abort_p,
  input  logic [ABRT_W-1:0]                 abort_why,
  input  logic                              start_p,
  input  logic                              stop_p,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   tx_level,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_level,
  output logic                              irq,
  output logic                              tx_fifo_hold
);
  localparam int THR_W = $clog2(FIFO_DEPTH);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);

  logic [NEV-1:0]    set_vec;
  logic [NEV-1:0]    clr_vec;
  logic [NEV-1:0]    raw;
  logic [NEV-1:0]    mask_q;
  logic [THR_W-1:0]  tx_thr;
  logic [THR_W-1:0]  rx_thr;
  logic [ABRT_W-1:0] abrt_src;
  logic              tx_empty_lvl;
  logic              rx_full_lvl;

  assign set_vec = {stop_p, start_p, 1'b0, 1'b0, abort_p, tx_over_p, rx_over_p, rx_under_p};

  assign tx_empty_lvl = tx_level <= LVL_W'(tx_thr);
  assign rx_full_lvl  = rx_level >  LVL_W'(rx_thr);

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    if (CLEARABLE[i]) begin : g_sticky
      assign clr_vec[i] = reg_rd && ((reg_addr == A_CLRALL) || (reg_addr == clr_addr_of(i)));
      i2cev_sticky u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec[i]),
        .clr   (clr_vec[i]),
        .q     (raw[i])
      );
    end else if (i == EV_TXE) begin : g_txe
      assign clr_vec[i] = 1'b0;
      assign raw[i]     = tx_empty_lvl;
    end else begin : g_rxf
      assign clr_vec[i] = 1'b0;
      assign raw[i]     = rx_full_lvl;
    end
  end

  i2cev_thr_reg #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txthr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_wr && (reg_addr == A_TXTHR)),
    .wdata (reg_wdata),
    .q     (tx_thr)
  );

  i2cev_thr_reg #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxthr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_wr && (reg_addr == A_RXTHR)),
    .wdata (reg_wdata),
    .q     (rx_thr)
  );

  i2cev_abort_src u_asrc (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (abort_p),
    .why     (abort_why),
    .clr     (clr_vec[EV_ABT]),
    .q       (abrt_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mask_q <= '0;
    else if (reg_wr && (reg_addr == A_MASK))  mask_q <= reg_wdata[NEV-1:0];
  end

  assign irq          = |(raw & mask_q);
  assign tx_fifo_hold = raw[EV_ABT];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RAW:    reg_rdata = DATA_W'(raw);
      A_MASK:   reg_rdata = DATA_W'(mask_q);
      A_STAT:   reg_rdata = DATA_W'(raw & mask_q);
      A_TXTHR:  reg_rdata = DATA_W'(tx_thr);
      A_RXTHR:  reg_rdata = DATA_W'(rx_thr);
      A_ASRC:   reg_rdata = DATA_W'(abrt_src);
      A_CLRALL: reg_rdata = DATA_W'(|(raw & CLEARABLE));
      default:  reg_rdata = '0;
    endcase
    for (int i = 0; i < NEV; i++) begin
      if (CLEARABLE[i] && (reg_addr == clr_addr_of(i))) reg_rdata = DATA_W'(raw[i]);
    end
  end
endmodule

// File: rtl/i2c_evt_status_chk.sv
module i2c_evt_status_chk
  import i2cev_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_rd,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [NEV-1:0]             raw,
  input logic [NEV-1:0]             set_vec,
  input logic [NEV-1:0]             mask_q,
  input logic [$clog2(FIFO_DEPTH)-1:0] tx_thr,
  input logic [ABRT_W-1:0]          abrt_src,
  input logic                       abort_p,
  input logic                       irq,
  input logic                       tx_fifo_hold
);
  localparam int THR_W = $clog2(FIFO_DEPTH);

  assert_event_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((raw & $past(set_vec)) == $past(set_vec)));

  assert_stop_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLR_STO && set_vec == '0)
      |=> (!raw[EV_STO] && ((raw & 8'h4F) == $past(raw & 8'h4F))));

  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLRALL && set_vec == '0) |=> ((raw & CLEARABLE) == '0));

  assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLR_ABT && !abort_p) |=> !tx_fifo_hold);

  assert_hold_on_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |=> tx_fifo_hold);

  assert_thr_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXTHR && reg_wdata > DATA_W'(FIFO_DEPTH-1))
      |=> (tx_thr == THR_W'(FIFO_DEPTH-1)));

  assert_cause_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLR_ABT && !abort_p) |=> (abrt_src == '0));

  assert_clear_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLRALL && start_or_stop(set_vec)) |=> (|raw[EV_STO:EV_STA]));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  function automatic logic start_or_stop(logic [NEV-1:0] v);
    return v[EV_STA] | v[EV_STO];
  endfunction
endmodule

bind i2c_evt_status i2c_evt_status_chk #(.FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd       (reg_rd),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .raw          (raw),
  .set_vec      (set_vec),
  .mask_q       (mask_q),
  .tx_thr       (tx_thr),
  .abrt_src     (abrt_src),
  .abort_p      (abort_p),
  .irq          (irq),
  .tx_fifo_hold (tx_fifo_hold)
);

// File: tb/sim_i2c_evt_status.sv
`timescale 1ns/100ps
module sim_i2c_evt_status;
  localparam int DEPTH = 8;
  localparam int DW    = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_under_p = 0, rx_over_p = 0, tx_over_p = 0, abort_p = 0, start_p = 0, stop_p = 0;
  logic [9:0]  abort_why = '0;
  logic [3:0]  tx_level = '0, rx_level = '0;
  logic        irq, tx_fifo_hold;

  int n_chk = 0, n_bad = 0;
  int tt = 0, rt = 0;   // bench copies of thresholds

  always #2.5 clk = ~clk;

  i2c_evt_status #(.FIFO_DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_under_p(rx_under_p),
    .rx_over_p(rx_over_p), .tx_over_p(tx_over_p), .abort_p(abort_p), .abort_why(abort_why),
    .start_p(start_p), .stop_p(stop_p), .tx_level(tx_level), .rx_level(rx_level),
    .irq(irq), .tx_fifo_hold(tx_fifo_hold));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one access cycle: drive after negedge, capture read data, release after posedge
  task automatic cyc(input logic [5:0] ev, input logic [9:0] why, input logic r, input logic w,
                     input logic [3:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    {stop_p, start_p, abort_p, tx_over_p, rx_over_p, rx_under_p} = ev;
    abort_why = why; reg_rd = r; reg_wr = w; reg_addr = a; reg_wdata = d;
    #1 q = reg_rdata;
    @(posedge clk); #1;
    {stop_p, start_p, abort_p, tx_over_p, rx_over_p, rx_under_p} = '0;
    abort_why = '0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    cyc(6'd0, 10'd0, 1'b1, 1'b0, a, 32'd0, q);
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] q;
    cyc(6'd0, 10'd0, 1'b0, 1'b1, a, d, q);
  endtask
  task automatic pulse(input logic [5:0] ev, input logic [9:0] why);
    logic [31:0] q;
    cyc(ev, why, 1'b0, 1'b0, 4'd0, 32'd0, q);
  endtask

  function automatic logic [7:0] ev2raw(input logic [5:0] e);
    return {e[5], e[4], 2'b00, e[3], e[2], e[1], e[0]};
  endfunction
  function automatic logic [7:0] clr_mask(input int a);
    case (a)
      6: return 8'hCF;  7: return 8'h01;  8: return 8'h02;
      9: return 8'h04; 10: return 8'h08; 11: return 8'h40;
      12: return 8'h80; default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] lvl_bits();
    return {2'b00, (int'(rx_level) > rt), (int'(tx_level) <= tt), 4'b0000};
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic [7:0]  exp8;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    #1;
    chk(irq == 1'b0, "R10 irq", irq, 0);
    chk(tx_fifo_hold == 1'b0, "R10 hold", tx_fifo_hold, 0);
    rd(4'd0, q);  chk(q == 32'h10, "R10 raw", q, 32'h10);
    rd(4'd1, q);  chk(q == 0, "R10 mask", q, 0);
    rd(4'd3, q);  chk(q == 0, "R10 txthr", q, 0);
    rd(4'd5, q);  chk(q == 0, "R10 abort causes", q, 0);

    // R1 every sticky event pattern
    for (int p = 0; p < 64; p++) begin
      rd(4'd6, q);
      pulse(6'(p), 10'h001);
      rd(4'd0, q);
      exp8 = ev2raw(6'(p)) | lvl_bits();
      chk(q[7:0] == exp8, "R1 raw latch", q, exp8);
    end

    // R2 / R3 each clear register against all events set
    for (int a = 6; a <= 12; a++) begin
      rd(4'd6, q);
      pulse(6'h3F, 10'h001);
      rd(4'(a), q);
      chk(q == 32'd1, (a == 6) ? "R3 clear-all read value" : "R2 clear read value", q, 1);
      rd(4'd0, q);
      exp8 = (ev2raw(6'h3F) & ~clr_mask(a)) | lvl_bits();
      chk(q[7:0] == exp8, (a == 6) ? "R3 clear-all" : "R2 single clear", q, exp8);
    end

    // R8 event in the same cycle as its clear read
    for (int a = 6; a <= 12; a++) begin
      for (int k = 0; k < 6; k++) begin
        rd(4'd6, q);
        cyc(6'(1 << k), 10'h002, 1'b1, 1'b0, 4'(a), 32'd0, q);
        rd(4'd0, q);
        exp8 = ev2raw(6'(1 << k)) | lvl_bits();
        chk(q[7:0] == exp8, "R8 set beats clear", q, exp8);
      end
    end
    rd(4'd6, q);
    pulse(6'h08, 10'h010);
    cyc(6'h08, 10'h100, 1'b1, 1'b0, 4'd10, 32'd0, q);
    rd(4'd5, q);
    chk(q == 32'h100, "R8 cause on abort-clear read", q, 32'h100);

    // R5 threshold saturation, both registers
    for (int v = 0; v <= 16; v++) begin
      logic [31:0] val, ex;
      val = (v == 16) ? 32'hFFFF_FFFF : 32'(v);
      ex  = (val > 32'(DEPTH - 1)) ? 32'(DEPTH - 1) : val;
      wr(4'd3, val); rd(4'd3, q); chk(q == ex, "R5 tx threshold", q, ex);
      wr(4'd4, val); rd(4'd4, q); chk(q == ex, "R5 rx threshold", q, ex);
    end

    // R6 level conditions over every threshold and level
    rd(4'd6, q);
    for (int t = 0; t < DEPTH; t++) begin
      wr(4'd3, 32'(t)); wr(4'd4, 32'(t)); tt = t; rt = t;
      for (int l = 0; l <= DEPTH; l++) begin
        tx_level = 4'(l); rx_level = 4'(DEPTH - l);
        rd(4'd0, q);
        exp8 = lvl_bits();
        chk(q[7:0] == exp8, "R6 level bits", q, exp8);
      end
    end
    // R6 clear-all does not touch level bits
    tx_level = 4'd0; rx_level = 4'd8;
    rd(4'd6, q); rd(4'd0, q);
    exp8 = lvl_bits();
    chk(q[7:0] == exp8, "R6 level bits survive clear-all", q, exp8);
    wr(4'd3, 0); wr(4'd4, 0); tt = 0; rt = 0; rx_level = 4'd0;

    // R9 mask sweep
    rd(4'd6, q);
    pulse(6'h3F, 10'h001);
    for (int m = 0; m < 256; m++) begin
      wr(4'd1, 32'(m));
      exp8 = (ev2raw(6'h3F) | lvl_bits()) & 8'(m);
      chk(irq == (|exp8), "R9 irq", irq, |exp8);
      rd(4'd2, q);
      chk(q[7:0] == exp8, "R9 masked status", q, exp8);
    end
    wr(4'd1, 0);

    // R7 / R4 abort causes and hold
    rd(4'd6, q);
    for (int b = 0; b < 10; b++) begin
      pulse(6'h08, 10'(1 << b));
      rd(4'd5, q);
      chk(q == 32'(1 << b), "R7 cause bit", q, 32'(1 << b));
      chk(tx_fifo_hold == 1'b1, "R4 hold set", tx_fifo_hold, 1);
      rd(4'd10, q);
      chk(tx_fifo_hold == 1'b0, "R4 hold released", tx_fifo_hold, 0);
    end
    pulse(6'h08, 10'h005);
    pulse(6'h08, 10'h240);
    rd(4'd5, q);  chk(q == 32'h245, "R7 causes accumulate", q, 32'h245);
    rd(4'd12, q); rd(4'd5, q);
    chk(q == 32'h245, "R7 stop clear leaves causes", q, 32'h245);
    chk(tx_fifo_hold == 1'b1, "R4 hold kept by other clear", tx_fifo_hold, 1);
    rd(4'd10, q); rd(4'd5, q);
    chk(q == 0, "R7 abort clear", q, 0);
    pulse(6'h08, 10'h3FF);
    rd(4'd6, q); rd(4'd5, q);
    chk(q == 0, "R7 clear-all clears causes", q, 0);
    chk(tx_fifo_hold == 1'b0, "R4 clear-all releases hold", tx_fifo_hold, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule